// File: doc/BRIEF.md
# Load-Aware Destination Selection Agent

This agent sits beside a source node that can hand its data to any of several identical downstream processing nodes. Each candidate node sends a short report once per allocation interval, giving how many free slots its input queue has and how many hops it lies from the source. The agent decides which candidate gets the source's traffic during the next interval.

The first report of an interval opens a collection window of a programmable length. Every report accepted in that window is queued in a small FIFO. When the window closes, the queue is drained one entry per cycle. For each entry a signed fitness is formed: free slots shifted left by one amount, minus hops shifted left by another. The agent tracks the best fitness and the address that produced it. When the queue is empty, it publishes that address with a one-cycle strobe.

A node that sends no report in the window is simply absent from that decision, so a dead node is routed around without any extra logic. The interval length, window length and both shift amounts are live inputs.

Top module: `dest_select_agent`

## Requirements
- R1: During and after reset, dest_valid_o and no_cand_o are 0 and dest_addr_o is 0.
- R2: The cycle that accepts the first report of an interval, together with the following W-1 cycles, forms the window; W = cfg_window_i, and a value of 0 counts as 1. Reports arriving outside the window are ignored until the next interval begins.
- R3: The fitness of a report equals (slots << cfg_slot_shift_i) - (hops << cfg_hop_shift_i), taken as a signed value without overflow, including the case where both shifts are at their maximum of 7.
- R4: dest_addr_o takes the address of the accepted report with the highest fitness. It changes only in the cycle in which dest_valid_o is high.
- R5: When two reports share the highest fitness, the one accepted first wins.
- R6: A change to either shift amount affects the next decision, with no reset needed.
- R7: If an interval ends with no report accepted, no_cand_o goes to 1 and dest_addr_o keeps its value. no_cand_o returns to 0 in the same cycle as the next dest_valid_o.
- R8: The FIFO holds DEPTH reports (default 8). Reports that arrive in the window while it is full are dropped and never take part in the decision.
- R9: dest_valid_o is high for exactly one cycle. It rises after the clock edge that lies W+N edges after the edge that accepted the first report, where N is the number of reports kept.
- R10: An interval lasts cfg_period_i cycles, counted from reset release. At most one decision is made per interval, and a new window can open only after the previous decision has completed and an interval boundary has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rpt_valid_i | input | 1 | A report is present this cycle |
| rpt_addr_i | input | ADDR_W | Address of the reporting node |
| rpt_slots_i | input | SLOT_W | Free input-queue slots of the reporting node |
| rpt_hops_i | input | HOP_W | Hop distance of the reporting node |
| cfg_period_i | input | T_W | Interval length in cycles |
| cfg_window_i | input | W_W | Collection window length in cycles |
| cfg_slot_shift_i | input | SHIFT_W | Left-shift weight applied to free slots |
| cfg_hop_shift_i | input | SHIFT_W | Left-shift weight applied to hops |
| dest_addr_o | output | ADDR_W | Selected destination address |
| dest_valid_o | output | 1 | One-cycle strobe for a new selection |
| no_cand_o | output | 1 | The last interval ended with no report |

## Verification
Most internal faults in this block show up at the port as a wrong winning address, and that mismatch appears in the very decision it affects. A window that is too short or too long changes which reports are kept. A FIFO pointer that is off by one repeats or loses an entry. A sign or shift error reorders candidates whose fitness is negative or large. A stuck state machine shows up differently. The strobe either never arrives, or arrives at a cycle other than W+N edges after the first report. Scenarios are therefore built so that the excluded report, or the later of two tied reports, would win if it were wrongly kept, and the strobe cycle is checked exactly.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_EVAL,
    ST_DONE
  } dsa_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dsa_period_timer.sv
module dsa_period_timer #(
  parameter int T_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [T_W-1:0] cfg_period_i,
  output logic           tick_o
);

  logic [T_W-1:0] cnt_q;
  logic [T_W-1:0] lim;

  always_comb begin
    lim    = (cfg_period_i == '0) ? '0 : cfg_period_i - T_W'(1);
    tick_o = (cnt_q >= lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + T_W'(1);
  end

endmodule

// File: rtl/dsa_report_fifo.sv
module dsa_report_fifo #(
  parameter int DW    = 14,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    din_i,
  input  logic             pop_i,
  output logic [DW-1:0]    dout_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    empty_o = (cnt_q == '0);
    full_o  = (cnt_q == CNT_W'(DEPTH));
    do_push = push_i && !full_o;
    do_pop  = pop_i && !empty_o;
    dout_o  = mem_q[rd_q];
    cnt_o   = cnt_q;
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_next(wr_q);
      if (do_pop)  rd_q <= ptr_next(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/dsa_fitness_max.sv
module dsa_fitness_max #(
  parameter int ADDR_W  = 4,
  parameter int SLOT_W  = 6,
  parameter int HOP_W   = 4,
  parameter int SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [SLOT_W-1:0]  slots_i,
  input  logic [HOP_W-1:0]   hops_i,
  input  logic [SHIFT_W-1:0] slot_sh_i,
  input  logic [SHIFT_W-1:0] hop_sh_i,
  output logic [ADDR_W-1:0]  best_addr_o
);

  localparam int MAX_SH = (1 << SHIFT_W) - 1;
  localparam int FIT_W  = dsa_pkg::max_int(SLOT_W, HOP_W) + MAX_SH + 2;

  logic [FIT_W-1:0]        slot_term, hop_term;
  logic signed [FIT_W-1:0] fit, best_q;
  logic                    have_q, better;
  logic [ADDR_W-1:0]       addr_q;

  always_comb begin
    slot_term = {{(FIT_W - SLOT_W){1'b0}}, slots_i} << slot_sh_i;
    hop_term  = {{(FIT_W - HOP_W){1'b0}}, hops_i} << hop_sh_i;
    fit       = $signed(slot_term) - $signed(hop_term);
    // strict compare: ties keep earlier entry
    better    = !have_q || (fit > best_q);
    best_addr_o = addr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      best_q <= '0;
      addr_q <= '0;
    end else if (clear_i) begin
      have_q <= 1'b0;
    end else if (load_i && better) begin
      have_q <= 1'b1;
      best_q <= fit;
      addr_q <= addr_i;
    end
  end

endmodule

// File: rtl/dest_select_agent.sv
module dest_select_agent
  import dsa_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int SLOT_W  = 6,
  parameter int HOP_W   = 4,
  parameter int SHIFT_W = 3,
  parameter int DEPTH   = 8,
  parameter int T_W     = 16,
  parameter int W_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rpt_valid_i,
  input  logic [ADDR_W-1:0]  rpt_addr_i,
  input  logic [SLOT_W-1:0]  rpt_slots_i,
  input  logic [HOP_W-1:0]   rpt_hops_i,
  input  logic [T_W-1:0]     cfg_period_i,
  input  logic [W_W-1:0]     cfg_window_i,
  input  logic [SHIFT_W-1:0] cfg_slot_shift_i,
  input  logic [SHIFT_W-1:0] cfg_hop_shift_i,
  output logic [ADDR_W-1:0]  dest_addr_o,
  output logic               dest_valid_o,
  output logic               no_cand_o
);

  localparam int RPT_W = ADDR_W + SLOT_W + HOP_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  dsa_state_e        st_q;
  logic [W_W-1:0]    win_q;
  logic              tick, accept, push, pop, commit, win_one, win_last;
  logic              fifo_empty, fifo_full;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [RPT_W-1:0]  head;
  logic [ADDR_W-1:0] head_addr, best_addr;
  logic [SLOT_W-1:0] head_slots;
  logic [HOP_W-1:0]  head_hops;

  dsa_period_timer #(.T_W(T_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_period_i (cfg_period_i),
    .tick_o       (tick)
  );

  always_comb begin
    accept   = rpt_valid_i && (st_q == ST_IDLE || st_q == ST_COLLECT);
    push     = accept && !fifo_full;
    pop      = (st_q == ST_EVAL) && !fifo_empty;
    commit   = (st_q == ST_EVAL) && fifo_empty;
    win_one  = (cfg_window_i <= W_W'(1));
    win_last = ({1'b0, win_q} + (W_W+1)'(1)) >= {1'b0, cfg_window_i};
    {head_addr, head_slots, head_hops} = head;
  end

  dsa_report_fifo #(.DW(RPT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   ({rpt_addr_i, rpt_slots_i, rpt_hops_i}),
    .pop_i   (pop),
    .dout_o  (head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .cnt_o   (fifo_cnt)
  );

  dsa_fitness_max #(
    .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .HOP_W(HOP_W), .SHIFT_W(SHIFT_W)
  ) u_fit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (commit),
    .load_i      (pop),
    .addr_i      (head_addr),
    .slots_i     (head_slots),
    .hops_i      (head_hops),
    .slot_sh_i   (cfg_slot_shift_i),
    .hop_sh_i    (cfg_hop_shift_i),
    .best_addr_o (best_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      win_q        <= '0;
      dest_addr_o  <= '0;
      dest_valid_o <= 1'b0;
      no_cand_o    <= 1'b0;
    end else begin
      dest_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            win_q <= W_W'(1);
            st_q  <= win_one ? ST_EVAL : ST_COLLECT;
          end else if (tick) begin
            no_cand_o <= 1'b1;
          end
        end
        ST_COLLECT: begin
          if (win_last) st_q <= ST_EVAL;
          else win_q <= win_q + W_W'(1);
        end
        ST_EVAL: begin
          if (commit) begin
            dest_addr_o  <= best_addr;
            dest_valid_o <= 1'b1;
            no_cand_o    <= 1'b0;
            st_q         <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (tick) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dsa_checker.sv
module dsa_checker #(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dest_valid_i,
  input logic [ADDR_W-1:0] dest_addr_i,
  input logic              no_cand_i,
  input logic [CNT_W-1:0]  fifo_cnt_i
);

  assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_valid_i |=> !dest_valid_i);

  assert_addr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dest_addr_i) |-> dest_valid_i);

  assert_cand_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_valid_i |-> !no_cand_i);

  assert_cand_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(no_cand_i) |-> (!dest_valid_i && $stable(dest_addr_i)));

  assert_fifo_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= CNT_W'(DEPTH));

endmodule

bind dest_select_agent dsa_checker #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dest_valid_i (dest_valid_o),
  .dest_addr_i  (dest_addr_o),
  .no_cand_i    (no_cand_o),
  .fifo_cnt_i   (fifo_cnt)
);

// File: tb/sim_dest_select_agent.sv
`timescale 1ns/1ps
module sim_dest_select_agent;

  localparam int ADDR_W = 4, SLOT_W = 6, HOP_W = 4, SHIFT_W = 3;
  localparam int DEPTH = 8, T_W = 16, W_W = 8;
  localparam int PER = 64;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               rpt_valid_i = 1'b0;
  logic [ADDR_W-1:0]  rpt_addr_i = '0;
  logic [SLOT_W-1:0]  rpt_slots_i = '0;
  logic [HOP_W-1:0]   rpt_hops_i = '0;
  logic [T_W-1:0]     cfg_period_i = T_W'(PER);
  logic [W_W-1:0]     cfg_window_i = W_W'(10);
  logic [SHIFT_W-1:0] cfg_slot_shift_i = '0;
  logic [SHIFT_W-1:0] cfg_hop_shift_i = '0;
  logic [ADDR_W-1:0]  dest_addr_o;
  logic               dest_valid_o;
  logic               no_cand_o;

  int total = 0, fails = 0, cyc = 0;
  int r_n;
  int r_off[16], r_addr[16], r_sl[16], r_hp[16];

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;

  dest_select_agent #(
    .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .HOP_W(HOP_W), .SHIFT_W(SHIFT_W),
    .DEPTH(DEPTH), .T_W(T_W), .W_W(W_W)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rpt_valid_i(rpt_valid_i), .rpt_addr_i(rpt_addr_i),
    .rpt_slots_i(rpt_slots_i), .rpt_hops_i(rpt_hops_i),
    .cfg_period_i(cfg_period_i), .cfg_window_i(cfg_window_i),
    .cfg_slot_shift_i(cfg_slot_shift_i), .cfg_hop_shift_i(cfg_hop_shift_i),
    .dest_addr_o(dest_addr_o), .dest_valid_o(dest_valid_o), .no_cand_o(no_cand_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // returns at the negedge right after an interval boundary
  task automatic wait_start();
    @(negedge clk);
    while (cyc == 0 || (cyc % PER) != 0) @(negedge clk);
  endtask

  task automatic add(input int off, input int a, input int s, input int h);
    r_off[r_n] = off; r_addr[r_n] = a; r_sl[r_n] = s; r_hp[r_n] = h;
    r_n++;
  endtask

  task automatic run_case(input string tag);
    int weff, first, n, best, bestf, f, exp_step, seen_step, seen_addr, pulses;
    weff  = (int'(cfg_window_i) < 1) ? 1 : int'(cfg_window_i);
    first = r_off[0];
    n = 0; best = 0; bestf = 0;
    for (int i = 0; i < r_n; i++) begin
      if (r_off[i] < first + weff && n < DEPTH) begin
        f = (r_sl[i] << cfg_slot_shift_i) - (r_hp[i] << cfg_hop_shift_i);
        if (n == 0 || f > bestf) begin bestf = f; best = r_addr[i]; end
        n++;
      end
    end
    exp_step = first + weff + n + 1;
    wait_start();
    pulses = 0; seen_step = -1; seen_addr = 0;
    for (int s = 0; s < 60; s++) begin
      if (dest_valid_o) begin
        pulses++;
        if (seen_step < 0) begin seen_step = s; seen_addr = int'(dest_addr_o); end
      end
      rpt_valid_i = 1'b0;
      for (int i = 0; i < r_n; i++) begin
        if (r_off[i] == s) begin
          rpt_valid_i = 1'b1;
          rpt_addr_i  = ADDR_W'(r_addr[i]);
          rpt_slots_i = SLOT_W'(r_sl[i]);
          rpt_hops_i  = HOP_W'(r_hp[i]);
        end
      end
      @(negedge clk);
    end
    rpt_valid_i = 1'b0;
    chk(pulses == 1, {tag, " R10 one decision per interval"}, pulses, 1);
    chk(seen_step == exp_step, {tag, " R9 strobe cycle"}, seen_step, exp_step);
    chk(seen_addr == best, tag, seen_addr, best);
    chk(no_cand_o == 1'b0, {tag, " R7 flag low after decision"}, int'(no_cand_o), 0);
    r_n = 0;
  endtask

  task automatic t_reset();
    chk(dest_valid_o == 1'b0, "R1 reset dest_valid", int'(dest_valid_o), 0);
    chk(dest_addr_o == '0, "R1 reset dest_addr", int'(dest_addr_o), 0);
    chk(no_cand_o == 1'b0, "R1 reset no_cand", int'(no_cand_o), 0);
  endtask

  task automatic t_basic();
    cfg_slot_shift_i = 3'd2; cfg_hop_shift_i = 3'd1;
    add(0, 3, 10, 2); add(1, 5, 8, 0); add(2, 7, 12, 1); add(3, 9, 11, 0);
    run_case("R4 weighted pick");
  endtask

  task automatic t_tie();
    cfg_slot_shift_i = 3'd1; cfg_hop_shift_i = 3'd1;
    add(3, 4, 5, 1); add(4, 6, 6, 2); add(7, 2, 4, 0);
    run_case("R5 tie keeps earliest");
  endtask

  task automatic t_negative();
    cfg_slot_shift_i = 3'd0; cfg_hop_shift_i = 3'd2;
    add(0, 2, 0, 9); add(1, 4, 0, 3); add(2, 8, 1, 5);
    run_case("R3 negative fitness");
  endtask

  task automatic t_wide();
    cfg_slot_shift_i = 3'd7; cfg_hop_shift_i = 3'd7;
    add(0, 3, 40, 0); add(1, 1, 63, 15); add(2, 5, 0, 15);
    run_case("R3 max shifts");
  endtask

  task automatic t_window();
    cfg_slot_shift_i = 3'd1; cfg_hop_shift_i = 3'd0;
    add(0, 1, 5, 0); add(5, 2, 7, 0); add(9, 3, 9, 0);
    add(10, 4, 30, 0); add(40, 5, 60, 0);
    run_case("R2 window edges");
  endtask

  task automatic t_shift_live();
    cfg_slot_shift_i = 3'd0; cfg_hop_shift_i = 3'd2;
    add(0, 6, 10, 4); add(1, 8, 6, 0);
    run_case("R6 shifts set A");
    cfg_slot_shift_i = 3'd3; cfg_hop_shift_i = 3'd0;
    add(0, 6, 10, 4); add(1, 8, 6, 0);
    run_case("R6 shifts set B");
  endtask

  task automatic t_silent();
    int pulses;
    pulses = 0;
    wait_start();
    for (int s = 0; s < PER; s++) begin
      if (dest_valid_o) pulses++;
      @(negedge clk);
    end
    chk(pulses == 0, "R7 no strobe in silent interval", pulses, 0);
    chk(no_cand_o == 1'b1, "R7 no_cand raised", int'(no_cand_o), 1);
    chk(dest_addr_o == 4'd6, "R7 dest held", int'(dest_addr_o), 6);
    cfg_slot_shift_i = 3'd2; cfg_hop_shift_i = 3'd1;
    add(0, 3, 10, 2); add(1, 5, 8, 0); add(2, 7, 12, 1);
    run_case("R7 recovery pick");
  endtask

  task automatic t_overflow();
    cfg_slot_shift_i = 3'd0; cfg_hop_shift_i = 3'd0;
    for (int i = 0; i < 10; i++) add(i, i, 5 * i + 1, 0);
    run_case("R8 full fifo drops");
  endtask

  task automatic t_window_one();
    cfg_window_i = W_W'(0);
    cfg_slot_shift_i = 3'd0; cfg_hop_shift_i = 3'd0;
    add(0, 2, 1, 0); add(1, 3, 50, 0);
    run_case("R2 zero window acts as one");
    cfg_window_i = W_W'(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    r_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_tie();
    t_negative();
    t_wide();
    t_window();
    t_shift_live();
    t_silent();
    t_overflow();
    t_window_one();
    summary();
    $finish;
  end

endmodule